// File: doc/BRIEF.md
# Four-Way Fixed Priority Bus Arbiter

This block decides which of four masters drives the shared system bus: an off-chip device, a DRAM refresh engine, a DMA controller and the CPU. The off-chip device asks for the bus by pulling an active-low request line low. It learns that the bus is free when the arbiter pulls an active-low acknowledge line low. The refresh engine and the DMA controller each use a request/grant pair. The CPU needs no request: it owns the bus whenever nobody else wants it.

Internal masters give up the bus only at access boundaries, which the owning master reports on a shared end-of-access strobe. An off-chip request therefore wins at the next boundary, even partway through a DMA burst. Every handover leaves one bus cycle with no owner. When the refresh engine needs the bus while the off-chip device holds it, the arbiter raises the acknowledge line early. It then waits for the device to withdraw its request, and after that it grants the refresh ahead of any new request from the device. The off-chip request passes through a flip-flop synchronizer before any decision uses it.

Top module: `bus_owner_arb`

## Requirements
- R1: While reset is active and on the first cycle after it, `cpu_gnt` is 1, `dma_gnt` and `rfsh_gnt` are 0, and `ext_ack_n` is 1.
- R2: In every cycle at most one of `cpu_gnt`, `dma_gnt`, `rfsh_gnt` and (`ext_ack_n` low) is active.
- R3: Whenever an active grant (or low `ext_ack_n`) is withdrawn, the following GAP_CYCLES cycles (default 1) have no grant and `ext_ack_n` high.
- R4: At the end of an idle gap the bus goes to the highest-priority requester: off-chip device (synchronized `ext_req_n` low), then refresh, then DMA. With no request pending it goes to the CPU.
- R5: An internal owner (CPU, DMA or refresh) loses its grant only after a cycle in which `xfer_end` was 1.
- R6: While DMA owns the bus with `dma_req` held at 1, a low `ext_req_n` takes the bus away at the next `xfer_end`. `ext_ack_n` goes low after the gap.
- R7: `ext_req_n` reaches the decision logic through a two-stage synchronizer. With the CPU owning and `xfer_end` at 1, `ext_ack_n` goes low after the fourth rising edge after `ext_req_n` falls.
- R8: While the off-chip device owns the bus, a high `ext_req_n` (after synchronization) raises `ext_ack_n`, and the bus passes on after the gap.
- R9: If `rfsh_req` is 1 while `ext_ack_n` is low, `ext_ack_n` is high after the next rising edge. No grant is given while `ext_req_n` stays low.
- R10: After an early release for refresh, once synchronized `ext_req_n` is high, the bus goes to refresh after the gap. This holds even if `ext_req_n` falls again during the gap.
- R11: DMA or refresh gives up the bus at an `xfer_end` where its own request has dropped to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_req_n | input | 1 | Off-chip bus request, active low, asynchronous |
| ext_ack_n | output | 1 | Off-chip bus acknowledge, low while the device owns the bus |
| rfsh_req | input | 1 | Refresh engine requests the bus |
| rfsh_gnt | output | 1 | Bus granted to the refresh engine |
| dma_req | input | 1 | DMA controller requests the bus |
| dma_gnt | output | 1 | Bus granted to the DMA controller |
| cpu_gnt | output | 1 | Bus granted to the CPU |
| xfer_end | input | 1 | The owning internal master is at an access boundary |

## Verification
Two events can land on the same clock edge. A refresh demand can arrive just as the off-chip device withdraws its request. The device can also re-request during the idle cycle that follows an early release. The bench provokes both with directed sequences, for example by dropping and re-raising `ext_req_n` one cycle apart while `rfsh_req` is held. It judges each outcome by the owner the priority and reclaim rules predict. Long random runs then let DMA boundaries, refresh demands and off-chip requests overlap freely. Every cycle is compared against a bench model written from the requirements.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [2:0] {
        OWN_CPU     = 3'd0,
        OWN_DMA     = 3'd1,
        OWN_RFSH    = 3'd2,
        OWN_EXT     = 3'd3,
        OWN_RECLAIM = 3'd4,
        OWN_GAP     = 3'd5
    } owner_e;

endpackage

// File: rtl/arb_req_sync.sv
module arb_req_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stage_d, stage_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb stage_d = {stage_q[LAST-1:0], async_in};
        end else begin : g_single
            always_comb stage_d = async_in;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick
    import bus_arb_pkg::*;
(
    input  logic   ext_rq,
    input  logic   rfsh_rq,
    input  logic   dma_rq,
    input  logic   rfsh_first,
    output owner_e winner
);
    always_comb begin
        if (rfsh_first && rfsh_rq) winner = OWN_RFSH;
        else if (ext_rq)           winner = OWN_EXT;
        else if (rfsh_rq)          winner = OWN_RFSH;
        else if (dma_rq)           winner = OWN_DMA;
        else                       winner = OWN_CPU;
    end
endmodule

// File: rtl/arb_owner_fsm.sv
module arb_owner_fsm
    import bus_arb_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ext_rq,
    input  logic   rfsh_req,
    input  logic   dma_req,
    input  logic   xfer_end,
    input  owner_e winner,
    output owner_e owner,
    output logic   rfsh_first
);
    localparam int            GW       = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    typedef struct packed {
        owner_e        own;
        logic [GW-1:0] cnt;
        logic          first;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q.own)
            OWN_CPU: begin
                if (xfer_end && (ext_rq || rfsh_req || dma_req)) begin
                    st_d.own = OWN_GAP;
                    st_d.cnt = '0;
                end
            end
            OWN_DMA: begin
                if (xfer_end && (ext_rq || rfsh_req || !dma_req)) begin
                    st_d.own = OWN_GAP;
                    st_d.cnt = '0;
                end
            end
            OWN_RFSH: begin
                if (xfer_end && (ext_rq || !rfsh_req)) begin
                    st_d.own = OWN_GAP;
                    st_d.cnt = '0;
                end
            end
            OWN_EXT: begin
                if (!ext_rq) begin
                    st_d.own = OWN_GAP;
                    st_d.cnt = '0;
                end else if (rfsh_req) begin
                    st_d.own = OWN_RECLAIM;
                end
            end
            OWN_RECLAIM: begin
                if (!ext_rq) begin
                    st_d.own   = OWN_GAP;
                    st_d.cnt   = '0;
                    st_d.first = 1'b1;
                end
            end
            OWN_GAP: begin
                if (st_q.cnt == GAP_LAST) begin
                    st_d.own   = winner;
                    st_d.cnt   = '0;
                    st_d.first = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt + GW'(1);
                end
            end
            default: begin
                st_d.own   = OWN_CPU;
                st_d.cnt   = '0;
                st_d.first = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.own   <= OWN_CPU;
            st_q.cnt   <= '0;
            st_q.first <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner      = st_q.own;
    assign rfsh_first = st_q.first;
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
    import bus_arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_CYCLES  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_n,
    output logic ext_ack_n,
    input  logic rfsh_req,
    output logic rfsh_gnt,
    input  logic dma_req,
    output logic dma_gnt,
    output logic cpu_gnt,
    input  logic xfer_end
);
    logic   req_n_sync;
    logic   ext_rq;
    logic   rfsh_first;
    owner_e winner;
    owner_e owner;

    arb_req_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_req_n),
        .sync_out (req_n_sync)
    );

    assign ext_rq = !req_n_sync;

    arb_prio_pick i_pick (
        .ext_rq     (ext_rq),
        .rfsh_rq    (rfsh_req),
        .dma_rq     (dma_req),
        .rfsh_first (rfsh_first),
        .winner     (winner)
    );

    arb_owner_fsm #(
        .GAP_CYCLES (GAP_CYCLES)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_rq     (ext_rq),
        .rfsh_req   (rfsh_req),
        .dma_req    (dma_req),
        .xfer_end   (xfer_end),
        .winner     (winner),
        .owner      (owner),
        .rfsh_first (rfsh_first)
    );

    always_comb begin
        cpu_gnt   = (owner == OWN_CPU);
        dma_gnt   = (owner == OWN_DMA);
        rfsh_gnt  = (owner == OWN_RFSH);
        ext_ack_n = (owner != OWN_EXT);
    end
endmodule

// File: rtl/bus_owner_arb_chk.sv
module bus_owner_arb_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_end,
    input logic rfsh_req,
    input logic cpu_gnt,
    input logic dma_gnt,
    input logic rfsh_gnt,
    input logic ext_ack_n
);
    logic [3:0] own_v;
    assign own_v = {!ext_ack_n, rfsh_gnt, dma_gnt, cpu_gnt};

    // R2
    a_r2_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(own_v) <= 1);

    // R3
    a_r3_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(own_v) != 4'b0) && (own_v != $past(own_v))) |-> (own_v == 4'b0));

    // R5
    a_r5_cpu_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_gnt) && !cpu_gnt) |-> $past(xfer_end));

    // R5
    a_r5_dma_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dma_gnt) && !dma_gnt) |-> $past(xfer_end));

    // R5
    a_r5_rfsh_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rfsh_gnt) && !rfsh_gnt) |-> $past(xfer_end));

    // R9
    a_r9_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!ext_ack_n) && $past(rfsh_req)) |-> ext_ack_n);
endmodule

bind bus_owner_arb bus_owner_arb_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer_end  (xfer_end),
    .rfsh_req  (rfsh_req),
    .cpu_gnt   (cpu_gnt),
    .dma_gnt   (dma_gnt),
    .rfsh_gnt  (rfsh_gnt),
    .ext_ack_n (ext_ack_n)
);

// File: tb/test_bus_owner_arb.sv
`timescale 1ns/1ps
module test_bus_owner_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req_n = 1'b1;
    logic rfsh_req = 1'b0;
    logic dma_req = 1'b0;
    logic xfer_end = 1'b0;
    logic ext_ack_n, rfsh_gnt, dma_gnt, cpu_gnt;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // model: 0 cpu, 1 dma, 2 refresh, 3 external, 4 reclaim, 5 gap
    int m_own   = 0;
    bit m_first = 1'b0;
    bit m_s1    = 1'b1;
    bit m_s2    = 1'b1;

    always #2.5 clk = ~clk;

    bus_owner_arb i_bus_owner_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_req_n (ext_req_n),
        .ext_ack_n (ext_ack_n),
        .rfsh_req  (rfsh_req),
        .rfsh_gnt  (rfsh_gnt),
        .dma_req   (dma_req),
        .dma_gnt   (dma_gnt),
        .cpu_gnt   (cpu_gnt),
        .xfer_end  (xfer_end)
    );

    function automatic int pick_model(bit e, bit r, bit d, bit f);
        if (f && r) return 2;
        if (e)      return 3;
        if (r)      return 2;
        if (d)      return 1;
        return 0;
    endfunction

    function automatic logic [3:0] model_out(int own);
        return {own == 3, own == 2, own == 1, own == 0};
    endfunction

    task automatic model_step();
        bit e;
        int n;
        bit nf;
        e  = !m_s2;
        n  = m_own;
        nf = m_first;
        case (m_own)
            0: if (xfer_end && (e || rfsh_req || dma_req)) n = 5;
            1: if (xfer_end && (e || rfsh_req || !dma_req)) n = 5;
            2: if (xfer_end && (e || !rfsh_req)) n = 5;
            3: if (!e) n = 5; else if (rfsh_req) n = 4;
            4: if (!e) begin n = 5; nf = 1'b1; end
            default: begin n = pick_model(e, rfsh_req, dma_req, m_first); nf = 1'b0; end
        endcase
        m_s2    = m_s1;
        m_s1    = ext_req_n;
        m_own   = n;
        m_first = nf;
    endtask

    task automatic check(string t, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: owners {ext,rfsh,dma,cpu} got %b expected %b at %0t", t, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] dut_out();
        return {!ext_ack_n, rfsh_gnt, dma_gnt, cpu_gnt};
    endfunction

    // drive inputs at a falling edge, advance the model, compare at next falling edge
    task automatic tick(bit e_n, bit r, bit d, bit x);
        ext_req_n = e_n;
        rfsh_req  = r;
        dma_req   = d;
        xfer_end  = x;
        model_step();
        @(negedge clk);
        check(tag, dut_out(), model_out(m_own));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0A17);
        repeat (4) @(negedge clk);
        // R1: reset state held and on first cycle after release
        check("R1", dut_out(), 4'b0001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", dut_out(), 4'b0001);

        // R7 and R4: off-chip request from CPU ownership, boundary held high
        tag = "R7";
        tick(0, 0, 0, 1);                       // edge 1
        check("R7", dut_out(), 4'b0001);
        tick(0, 0, 0, 1);                       // edge 2
        check("R7", dut_out(), 4'b0001);
        tick(0, 0, 0, 1);                       // edge 3: gap
        check("R3", dut_out(), 4'b0000);
        tick(0, 0, 0, 1);                       // edge 4: external owns
        check("R7", dut_out(), 4'b1000);

        // R8: device drops request; bus returns to CPU after gap
        tag = "R8";
        for (int i = 0; i < 3; i++) tick(1, 0, 0, 0);
        check("R8", dut_out(), 4'b0000);
        tick(1, 0, 0, 0);
        check("R8", dut_out(), 4'b0001);

        // R5 and R4: DMA waits for boundary, then wins over CPU
        tag = "R5";
        for (int i = 0; i < 4; i++) tick(1, 0, 1, 0);
        check("R5", dut_out(), 4'b0001);
        tick(1, 0, 1, 1);
        tick(1, 0, 1, 0);
        check("R4", dut_out(), 4'b0010);

        // R6: off-chip request preempts a DMA burst at the next boundary
        tag = "R6";
        for (int i = 0; i < 5; i++) tick(0, 0, 1, 0);
        check("R6", dut_out(), 4'b0010);
        tick(0, 0, 1, 1);
        check("R6", dut_out(), 4'b0000);
        tick(0, 0, 1, 0);
        check("R6", dut_out(), 4'b1000);

        // R9: refresh while device owns -> acknowledge raised, no grant
        tag = "R9";
        tick(0, 1, 1, 0);
        check("R9", dut_out(), 4'b0000);
        for (int i = 0; i < 3; i++) tick(0, 1, 1, 0);
        check("R9", dut_out(), 4'b0000);

        // R10: device drops then re-requests during the gap; refresh still wins
        tag = "R10";
        tick(1, 1, 1, 0);
        tick(0, 1, 1, 0);
        tick(0, 1, 1, 0);
        check("R10", dut_out(), 4'b0000);
        tick(0, 1, 1, 0);
        check("R10", dut_out(), 4'b0100);

        // R11: refresh releases once its request drops at a boundary; device next
        tag = "R11";
        tick(0, 1, 1, 0);
        tick(0, 0, 1, 1);
        check("R11", dut_out(), 4'b0000);
        tick(0, 0, 1, 0);
        check("R4", dut_out(), 4'b1000);
        for (int i = 0; i < 4; i++) tick(1, 0, 0, 0);
        check("R4", dut_out(), 4'b0001);

        // R11: DMA releases once dma_req drops at a boundary
        tick(1, 0, 1, 1);
        tick(1, 0, 1, 1);
        check("R11", dut_out(), 4'b0010);
        tick(1, 0, 0, 1);
        check("R11", dut_out(), 4'b0000);
        tick(1, 0, 0, 0);
        check("R11", dut_out(), 4'b0001);

        // R2 R3 R4: random mix compared against the model every cycle
        tag = "R2/R3/R4 random";
        for (int i = 0; i < 4000; i++) begin
            bit e_n, r, d, x;
            e_n = ext_req_n;
            r   = rfsh_req;
            d   = dma_req;
            if ($urandom % 9 == 0) e_n = ~e_n;
            if ($urandom % 11 == 0) r = ~r;
            if ($urandom % 7 == 0) d = ~d;
            x = ($urandom % 3) != 0;
            tick(e_n, r, d, x);
        end
        summary();
    end
endmodule